// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a programmed number of seconds and raises an alarm when the count runs out. Software writes the number of seconds still to wait into a 32-bit count register, then sets the run bit. Each pulse on the 1 Hz tick input then takes one off the count, as long as the run bit is set and the count is not yet zero. The tick that takes the count from one to zero sets a sticky pending flag. Software clears this flag by writing a one to it.

Two outputs come from the pending flag, and each has its own gate. The interrupt output is high while the flag is pending and the interrupt-enable bit is set. The wakeup output also needs the wake-enable bit. The registers sit on a simple single-cycle write port. Reads are combinational and decode the same address.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset the count is 0 and the run, interrupt-enable, wake-enable and pending bits are 0. irq and wake are low.
- R2: A write to offset 0x20 loads the count with wr_data. The new value reads back at offsets 0x20 and 0x24 from the next cycle.
- R3: On a cycle with tick_1hz high, run (bit 0 at 0x28) set, a nonzero count and no write at 0x20, the count drops by one. On any other cycle without a write at 0x20, the count holds.
- R4: The tick that takes the count from 1 to 0 sets the pending flag. The flag reads as bit 0 at 0x30.
- R5: A count of zero with run set stays zero, and ticks on it never set the pending flag.
- R6: Writing 1 to bit 0 at 0x30 clears the pending flag, and writing 0 there has no effect. If a clear and a 1-to-0 tick fall in the same cycle, the flag is set.
- R7: irq is high exactly when the pending flag and the interrupt-enable bit (bit 0 at 0x2C) are both 1.
- R8: wake is high exactly when irq is high and the wake-enable bit (bit 0 at 0x50) is 1.
- R9: A write at 0x20 leaves the pending flag as it was. If it falls in the same cycle as a tick, the load wins and no decrement happens.
- R10: The control registers at 0x28, 0x2C, 0x30 and 0x50 read back with only bit 0 meaningful and bits 31:1 as zero. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wakeup request |

## Verification
The assertions check on every cycle that:
- the count holds without a tick, drops by exactly one on a qualifying tick, and loads the written value;
- the pending flag sets on the one-to-zero tick and otherwise stays low until set;
- a pending flag survives any cycle without a clear;
- wake never rises without irq.

The bench's scenarios show the rest:
- the order of the interrupt gates, checked against its reference model;
- the case where a clear and a set fall in the same cycle;
- the case where a load and a tick fall in the same cycle;
- zero-count ticks with run set, ticks with run clear, and readback of the unused high bits.

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm #(
  parameter int AW = 8,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic          irq,
  output logic          wake
);
  localparam logic [AW-1:0] A_LOAD = AW'('h20);
  localparam logic [AW-1:0] A_LEFT = AW'('h24);
  localparam logic [AW-1:0] A_RUN  = AW'('h28);
  localparam logic [AW-1:0] A_IEN  = AW'('h2C);
  localparam logic [AW-1:0] A_STAT = AW'('h30);
  localparam logic [AW-1:0] A_WKEN = AW'('h50);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] count;
  logic run, ien, wken, pend;

  logic load, step, expire, clr;
  assign load   = wr_en && (addr == A_LOAD);
  assign step   = tick_1hz && run && (count != '0) && !load;
  assign expire = step && (count == ONE);
  assign clr    = wr_en && (addr == A_STAT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      run   <= 1'b0;
      ien   <= 1'b0;
      wken  <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (load)      count <= wr_data;
      else if (step) count <= count - ONE;
      if (wr_en && addr == A_RUN)  run  <= wr_data[0];
      if (wr_en && addr == A_IEN)  ien  <= wr_data[0];
      if (wr_en && addr == A_WKEN) wken <= wr_data[0];
      if (expire)   pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_LOAD, A_LEFT: rd_data = count;
      A_RUN:          rd_data = CW'(run);
      A_IEN:          rd_data = CW'(ien);
      A_STAT:         rd_data = CW'(pend);
      A_WKEN:         rd_data = CW'(wken);
      default:        rd_data = '0;
    endcase
  end

  assign irq  = pend & ien;
  assign wake = irq & wken;
endmodule

module sec_countdown_alarm_chk #(
  parameter int AW = 8,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1hz,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] count,
  input logic          run,
  input logic          pend,
  input logic          irq,
  input logic          wake
);
  logic ld, go;
  assign ld = wr_en && (addr == AW'('h20));
  assign go = tick_1hz && run && (count != '0) && !ld;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count == $past(wr_data)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !go) |=> $stable(count)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> count == $past(count) - CW'(1)); // R3
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && count == CW'(1)) |=> pend); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !(go && count == CW'(1))) |=> !pend); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(wr_en && addr == AW'('h30) && wr_data[0])) |=> pend); // R6
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq); // R8
endmodule

bind sec_countdown_alarm sec_countdown_alarm_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .count(count), .run(run), .pend(pend), .irq(irq), .wake(wake)
);

// File: tb/sec_countdown_alarm_bench.sv
module sec_countdown_alarm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq, wake;

  always #10 clk = ~clk;

  sec_countdown_alarm u_sec_countdown_alarm (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .wake(wake)
  );

  int errors = 0, checks = 0;
  longint m_cnt = 0;
  bit m_run, m_ien, m_wk, m_pend;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint model_rd(input logic [7:0] a);
    case (a)
      8'h20, 8'h24: return m_cnt;
      8'h28: return longint'(m_run);
      8'h2C: return longint'(m_ien);
      8'h30: return longint'(m_pend);
      8'h50: return longint'(m_wk);
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (a == 8'h20 || a == 8'h24) return "R3";
    if (a == 8'h30) return "R4";
    return "R10";
  endfunction

  task automatic compare_all();
    chk(irq == (m_pend && m_ien), "R7", irq, m_pend && m_ien);
    chk(wake == (m_pend && m_ien && m_wk), "R8", wake, m_pend && m_ien && m_wk);
    chk(longint'(rd_data) == model_rd(addr), rd_tag(addr), rd_data, model_rd(addr));
  endtask

  task automatic cyc(input bit t, input bit w, input logic [7:0] a, input logic [31:0] d);
    bit setp, clrp, ld;
    @(negedge clk);
    tick_1hz = t; wr_en = w; addr = a; wr_data = d;
    ld = w && a == 8'h20;
    setp = 0;
    clrp = w && a == 8'h30 && d[0];
    if (ld) m_cnt = longint'(d);
    else if (t && m_run && m_cnt != 0) begin
      if (m_cnt == 1) setp = 1;
      m_cnt = m_cnt - 1;
    end
    if (w && a == 8'h28) m_run = d[0];
    if (w && a == 8'h2C) m_ien = d[0];
    if (w && a == 8'h50) m_wk = d[0];
    if (setp) m_pend = 1;
    else if (clrp) m_pend = 0;
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic rd_expect(input logic [7:0] a, input longint exp, input string tag);
    cyc(0, 0, a, 32'h0);
    chk(longint'(rd_data) == exp, tag, rd_data, exp);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(irq == 0 && wake == 0, "R1", {irq, wake}, 0);
    rd_expect(8'h24, 0, "R1");
    rd_expect(8'h30, 0, "R1");
    // R2 load
    cyc(0, 1, 8'h20, 32'd3);
    rd_expect(8'h24, 3, "R2");
    rd_expect(8'h20, 3, "R2");
    // R3 disabled tick holds
    cyc(1, 0, 8'h24, 0);
    chk(rd_data == 3, "R3", rd_data, 3);
    cyc(0, 1, 8'h28, 32'hFFFF_FFFF);
    rd_expect(8'h28, 1, "R10");
    cyc(1, 0, 8'h24, 0);
    chk(rd_data == 2, "R3", rd_data, 2);
    cyc(0, 0, 8'h24, 0);
    chk(rd_data == 2, "R3", rd_data, 2);
    cyc(1, 0, 8'h24, 0);
    cyc(1, 0, 8'h30, 0);
    chk(rd_data == 1, "R4", rd_data, 1);
    // pending but interrupt disabled
    chk(irq == 0, "R7", irq, 0);
    cyc(0, 1, 8'h2C, 32'h1);
    chk(irq == 1 && wake == 0, "R7", {irq, wake}, 2'b10);
    cyc(0, 1, 8'h50, 32'h1);
    chk(wake == 1, "R8", wake, 1);
    // R5 zero while enabled
    repeat (3) cyc(1, 0, 8'h24, 0);
    chk(rd_data == 0, "R5", rd_data, 0);
    // R6 write 0 no effect, write 1 clears
    cyc(0, 1, 8'h30, 32'h0);
    rd_expect(8'h30, 1, "R6");
    cyc(0, 1, 8'h30, 32'h1);
    rd_expect(8'h30, 0, "R6");
    chk(irq == 0 && wake == 0, "R6", {irq, wake}, 0);
    repeat (2) cyc(1, 0, 8'h30, 0);
    chk(rd_data == 0, "R5", rd_data, 0);
    // R9 reload with pending kept
    cyc(0, 1, 8'h20, 32'd1);
    cyc(1, 0, 8'h24, 0);
    cyc(0, 1, 8'h20, 32'd5);
    rd_expect(8'h30, 1, "R9");
    rd_expect(8'h24, 5, "R9");
    // R9 load wins over tick
    cyc(1, 1, 8'h20, 32'd9);
    rd_expect(8'h24, 9, "R9");
    // R6 set wins over clear in same cycle
    cyc(0, 1, 8'h30, 32'h1);
    cyc(0, 1, 8'h20, 32'd1);
    cyc(0, 1, 8'h30, 32'h1);
    rd_expect(8'h30, 0, "R6");
    cyc(0, 1, 8'h20, 32'd1);
    @(negedge clk);
    tick_1hz = 1; wr_en = 1; addr = 8'h30; wr_data = 32'h1;
    m_cnt = 0; m_pend = 1;
    @(posedge clk);
    #1;
    compare_all();
    rd_expect(8'h30, 1, "R6");
    // large count and upper bits
    cyc(0, 1, 8'h20, 32'hFFFF_FFFF);
    cyc(1, 0, 8'h24, 0);
    chk(rd_data == 32'hFFFF_FFFE, "R3", rd_data, 32'hFFFF_FFFE);
    rd_expect(8'h2C, 1, "R10");
    rd_expect(8'h50, 1, "R10");
    rd_expect(8'h44, 0, "R10");
    cyc(0, 1, 8'h28, 32'h0);
    cyc(1, 0, 8'h24, 0);
    chk(rd_data == 32'hFFFF_FFFE, "R3", rd_data, 32'hFFFF_FFFE);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule